// File: doc/BRIEF.md
# Dual-Channel Edge-Aligned PWM Timer with Period-Synchronised Compare Buffers

The block is a two-channel, 16-bit pulse-width modulation timer built around one shared up-counter. The counter starts from zero and returns to zero on the cycle after it equals a programmable period value. Each channel has two duty-compare registers that drive a pair of PWM outputs with their complements. Each channel also has two further compare registers that can act as shadow copies of the duty registers. When they do, their contents are copied into the duty registers only at the period match, so a new duty ratio always starts on a clean period boundary.

Buffering for both channels is selected by the two buffer-enable bits of channel 0 alone. Channel 1's own buffer-enable bits must stay at 0 in this mode. Its A-side bit, if set, only silences the complement of its A output. Every compare register has a sticky match flag that is cleared by writing one. While a register serves as a buffer, its flag is never raised. Software sets up the block through a plain write port and reads it back through a combinational read port.

Top module: `pwm_rs_timer`

## Requirements
- R1: While the run bit (control register at address 0, bit 0) is 1, the counter (readable at address 11) goes up by one every clock. While the run bit is 0, the counter holds its value.
- R2: When the counter equals the period register (address 1) and run is 1, the counter is 0 in the next cycle.
- R3: Output pwm_p[2*ch+k] (k=0 for duty register A, k=1 for B) becomes 1 in the cycle after a period match. It becomes 0 in the cycle after the counter equals that duty register. A period match wins when both happen together. Duty registers are at addresses 2 (ch0 A), 3 (ch0 B), 6 (ch1 A) and 7 (ch1 B).
- R4: Each pwm_n bit is 0 until its output has seen its first period match. From then on it is the inverse of the matching pwm_p bit.
- R5: With control bit 1 set, register C (addresses 4 and 8) is copied into register A of the same channel at each period match, for both channels. With control bit 2 set, register D (addresses 5 and 9) is copied into register B in the same way. No copy happens at any other time.
- R6: Control bits 3 and 4 (channel 1's own buffer-enable bits) never cause any copy between registers.
- R7: While control bit 3 is 1, pwm_n[2] is held at 0.
- R8: With buffering off, a write to a duty register takes effect on the next compare, within the current period.
- R9: Flag register (address 10) bit 4*ch+k (k: A=0, B=1, C=2, D=3) is set when run is 1 and the counter equals that compare register. The bit stays set until it is cleared.
- R10: While control bit 1 is set, the C flags (bits 2 and 6) are never set. While control bit 2 is set, the D flags (bits 3 and 7) are never set.
- R11: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a match happens in the same cycle as the clear, the flag stays set.
- R12: After reset, every register, the counter and all flags read 0, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 16 | Combinational read data |
| pwm_p | output | 4 | PWM outputs, index 2*channel+k |
| pwm_n | output | 4 | Complementary PWM outputs |

## Verification
The hardest situation to bring about from the ports is a flag clear that lands on the exact edge where the counter matches that flag's register. The bench polls the counter at each falling edge. It raises the clear strobe in that same half-cycle, as soon as it reads the matching count, so the clear and the match share one rising edge. The shadow transfer is also hard to pin down. The bench writes the shadow just after an observed wrap, confirms the duty register has not changed yet, and then reads it again after the next observed wrap.

// File: rtl/pwm_rs_pkg.sv
package pwm_rs_pkg;

    localparam int CMP_PER_CH = 4;
    localparam int OUT_PER_CH = 2;
    localparam int NUM_CH     = 2;

    // control register layout, bit 0 is run
    typedef struct packed {
        logic ch1_buf_b;
        logic ch1_buf_a;
        logic ch0_buf_b;
        logic ch0_buf_a;
        logic run;
    } ctrl_t;

    typedef enum logic [3:0] {
        ADR_CTRL   = 4'd0,
        ADR_PERIOD = 4'd1,
        ADR_FLAGS  = 4'd10,
        ADR_COUNT  = 4'd11
    } adr_e;

    localparam logic [3:0] ADR_CMP_FIRST = 4'd2;
    localparam logic [3:0] ADR_CMP_LAST  = 4'd9;

endpackage

// File: rtl/pwm_rs_counter.sv
module pwm_rs_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign wrap_o = run && (cnt_q == period);
    assign cnt_o  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run) begin
            if (cnt_q == period) cnt_d = '0;
            else                 cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));

    // R1
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap_o) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/pwm_rs_channel.sv
module pwm_rs_channel #(
    parameter int  CW       = 16,
    parameter bit  HAS_GATE = 1'b0
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  run,
    input  logic [CW-1:0]                         cnt,
    input  logic                                  wrap,
    input  logic                                  buf_a,
    input  logic                                  buf_b,
    input  logic                                  c_pin_off,
    input  logic [pwm_rs_pkg::CMP_PER_CH-1:0]     wr_sel,
    input  logic [CW-1:0]                         wr_data,
    input  logic [pwm_rs_pkg::CMP_PER_CH-1:0]     flag_clr,
    output logic [pwm_rs_pkg::CMP_PER_CH-1:0][CW-1:0] regs_o,
    output logic [pwm_rs_pkg::CMP_PER_CH-1:0]     flags_o,
    output logic [pwm_rs_pkg::OUT_PER_CH-1:0]     pos_o,
    output logic [pwm_rs_pkg::OUT_PER_CH-1:0]     neg_o
);
    import pwm_rs_pkg::*;

    typedef struct packed {
        logic [CMP_PER_CH-1:0][CW-1:0] cmp;
        logic [CMP_PER_CH-1:0]         flags;
        logic [OUT_PER_CH-1:0]         pos;
        logic [OUT_PER_CH-1:0]         live;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic [CMP_PER_CH-1:0] hit;
    logic [CMP_PER_CH-1:0] hit_ok;

    for (genvar g = 0; g < CMP_PER_CH; g++) begin : g_hit
        assign hit[g] = run && (cnt == st_q.cmp[g]);
    end

    // registers serving as shadows raise no flag
    assign hit_ok = hit & ~{buf_b, buf_a, 2'b00};

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < CMP_PER_CH; k++) begin
            if (wr_sel[k]) st_d.cmp[k] = wr_data;
        end
        if (wrap && buf_a) st_d.cmp[0] = st_q.cmp[2];
        if (wrap && buf_b) st_d.cmp[1] = st_q.cmp[3];
        st_d.flags = (st_q.flags & ~flag_clr) | hit_ok;
        for (int k = 0; k < OUT_PER_CH; k++) begin
            if (wrap) begin
                st_d.pos[k]  = 1'b1;
                st_d.live[k] = 1'b1;
            end else if (hit[k]) begin
                st_d.pos[k]  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o  = st_q.cmp;
    assign flags_o = st_q.flags;
    assign pos_o   = st_q.pos;

    for (genvar g = 0; g < OUT_PER_CH; g++) begin : g_neg
        if (HAS_GATE && g == 0) begin : g_gated
            assign neg_o[g] = st_q.live[g] & ~st_q.pos[g] & ~c_pin_off;
        end else begin : g_plain
            assign neg_o[g] = st_q.live[g] & ~st_q.pos[g];
        end
    end

    // R5
    a_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && buf_a) |=> (st_q.cmp[0] == $past(st_q.cmp[2])));

    // R5
    b_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && buf_b) |=> (st_q.cmp[1] == $past(st_q.cmp[3])));

    // R10
    c_flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_a && !st_q.flags[2]) |=> !st_q.flags[2]);

    // R3
    rise_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (pos_o == '1));

    // R11
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ok[0] |=> flags_o[0]);

endmodule

// File: rtl/pwm_rs_timer.sv
module pwm_rs_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [3:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    output logic [3:0]    pwm_p,
    output logic [3:0]    pwm_n
);
    import pwm_rs_pkg::*;

    localparam int NFLAG = NUM_CH * CMP_PER_CH;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [CW-1:0] period;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [CW-1:0]                             cnt;
    logic                                      wrap;
    logic [NUM_CH-1:0][CMP_PER_CH-1:0][CW-1:0] ch_regs;
    logic [NUM_CH-1:0][CMP_PER_CH-1:0]         ch_flags;
    logic [NUM_CH-1:0][CMP_PER_CH-1:0]         ch_wsel;
    logic [NUM_CH-1:0][CMP_PER_CH-1:0]         ch_fclr;
    logic [NUM_CH-1:0][OUT_PER_CH-1:0]         ch_pos;
    logic [NUM_CH-1:0][OUT_PER_CH-1:0]         ch_neg;
    logic [3:0]                                widx;
    logic [3:0]                                ridx;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_addr == ADR_CTRL)   st_d.ctrl   = ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
        if (wr_en && wr_addr == ADR_PERIOD) st_d.period = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign widx = wr_addr - ADR_CMP_FIRST;

    always_comb begin
        ch_wsel = '0;
        ch_fclr = '0;
        if (wr_en && wr_addr >= ADR_CMP_FIRST && wr_addr <= ADR_CMP_LAST)
            ch_wsel[widx[2]][widx[1:0]] = 1'b1;
        if (wr_en && wr_addr == ADR_FLAGS)
            ch_fclr = wr_data[NFLAG-1:0];
    end

    pwm_rs_counter #(.CW(CW)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.ctrl.run),
        .period (st_q.period),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_rs_channel #(.CW(CW), .HAS_GATE(g != 0)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (st_q.ctrl.run),
            .cnt       (cnt),
            .wrap      (wrap),
            .buf_a     (st_q.ctrl.ch0_buf_a),
            .buf_b     (st_q.ctrl.ch0_buf_b),
            .c_pin_off (st_q.ctrl.ch1_buf_a),
            .wr_sel    (ch_wsel[g]),
            .wr_data   (wr_data),
            .flag_clr  (ch_fclr[g]),
            .regs_o    (ch_regs[g]),
            .flags_o   (ch_flags[g]),
            .pos_o     (ch_pos[g]),
            .neg_o     (ch_neg[g])
        );
    end

    assign pwm_p = ch_pos;
    assign pwm_n = ch_neg;

    assign ridx = rd_addr - ADR_CMP_FIRST;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_CTRL)        rd_data = CW'(st_q.ctrl);
        else if (rd_addr == ADR_PERIOD) rd_data = st_q.period;
        else if (rd_addr == ADR_FLAGS)  rd_data = CW'(ch_flags);
        else if (rd_addr == ADR_COUNT)  rd_data = cnt;
        else if (rd_addr >= ADR_CMP_FIRST && rd_addr <= ADR_CMP_LAST)
            rd_data = ch_regs[ridx[2]][ridx[1:0]];
    end

    // R7
    c_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.ch1_buf_a |=> (st_q.ctrl.ch1_buf_a ? !pwm_n[2] : 1'b1));

    // R6
    ch1_bits_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.ch0_buf_a && !(wr_en && wr_addr == 4'd6)) |=> $stable(ch_regs[1][0]));

endmodule

// File: tb/pwm_rs_timer_tb_top.sv
module pwm_rs_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  pwm_p;
    logic [3:0]  pwm_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm_rs_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_p   (pwm_p),
        .pwm_n   (pwm_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_zero();
        logic [15:0] c;
        do begin
            @(negedge clk);
            rd(4'd11, c);
        end while (c != 16'd0);
    endtask

    function automatic bit exp_pos(int c, int d, int p);
        return (d >= p) || (c <= d);
    endfunction

    // samples one full period starting at an observed zero count
    task automatic sample_period(input int p, input int d0a, input int d0b,
                                 input int d1a, input int d1b, input bit gate_c);
        logic [15:0] c;
        int duty[4];
        logic [3:0] ep;
        logic [3:0] en;
        duty[0] = d0a; duty[1] = d0b; duty[2] = d1a; duty[3] = d1b;
        rd(4'd11, c);
        for (int i = 0; i <= p; i++) begin
            chk("R1 count step", 32'(c), 32'(i));
            for (int k = 0; k < 4; k++) ep[k] = exp_pos(i, duty[k], p);
            en = ~ep;
            if (gate_c) en[2] = 1'b0;
            chk("R3 pwm_p", 32'(pwm_p), 32'(ep));
            if (gate_c) chk("R7 pwm_n gated", 32'(pwm_n), 32'(en));
            else        chk("R4 pwm_n", 32'(pwm_n), 32'(en));
            @(negedge clk);
            rd(4'd11, c);
        end
        chk("R2 wrap to zero", 32'(c), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] c1;
        logic [15:0] a_old;
        int p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            chk("R12 reset reg", 32'(v), 32'd0);
        end
        chk("R12 reset pwm_p", 32'(pwm_p), 32'd0);
        chk("R12 reset pwm_n", 32'(pwm_n), 32'd0);

        // R1 counting and hold
        wr(4'd1, 16'd20);
        wr(4'd2, 16'd3);
        wr(4'd0, 16'h0001);
        for (int i = 0; i < 4; i++) begin
            rd(4'd11, v);
            chk("R1 count from zero", 32'(v), 32'(i));
            if (i == 2) begin
                chk("R4 no complement before first wrap", 32'(pwm_n), 32'd0);
                chk("R4 no pwm before first wrap", 32'(pwm_p), 32'd0);
            end
            @(negedge clk);
        end
        wr(4'd0, 16'h0000);
        rd(4'd11, c1);
        repeat (3) @(negedge clk);
        rd(4'd11, v);
        chk("R1 hold when stopped", 32'(v), 32'(c1));
        wr(4'd0, 16'h0001);

        // R3 R4 R8 sweep over periods and duties, no buffering
        for (int pi = 0; pi < 3; pi++) begin
            p = (pi == 0) ? 3 : (pi == 1) ? 6 : 12;
            wait_zero();
            wr(4'd1, 16'(p));
            for (int d = 0; d <= p + 1; d++) begin
                int b0;
                b0 = (d <= p) ? p - d : p + 1;
                wr(4'd2, 16'(d));
                wr(4'd3, 16'(b0));
                wr(4'd6, 16'(d + 1));
                wr(4'd7, 16'(d / 2));
                wait_zero();
                sample_period(p, d, b0, d + 1, d / 2, 1'b0);
            end
        end

        // R8 immediate duty update within the current period
        wait_zero();
        wr(4'd2, 16'd10);
        do begin @(negedge clk); rd(4'd11, v); end while (v != 16'd10);
        chk("R8 still high at duty", 32'(pwm_p[0]), 32'd1);
        @(negedge clk);
        chk("R8 low after new duty", 32'(pwm_p[0]), 32'd0);

        // R5 buffered transfers
        wr(4'd2, 16'd6);
        rd(4'd2, a_old);
        wr(4'd4, 16'd2);
        wr(4'd8, 16'd7);
        wr(4'd5, 16'd4);
        wr(4'd9, 16'd9);
        wait_zero();
        rd(4'd2, v);
        chk("R5 no copy while unbuffered", 32'(v), 32'(a_old));
        wr(4'd0, 16'h0007);
        rd(4'd2, v);
        chk("R5 no copy before wrap", 32'(v), 32'(a_old));
        wait_zero();
        rd(4'd2, v); chk("R5 ch0 A from C", 32'(v), 32'd2);
        rd(4'd6, v); chk("R5 ch1 A from C", 32'(v), 32'd7);
        rd(4'd3, v); chk("R5 ch0 B from D", 32'(v), 32'd4);
        rd(4'd7, v); chk("R5 ch1 B from D", 32'(v), 32'd9);
        wr(4'd4, 16'd5);
        rd(4'd2, v); chk("R5 mid-period C write held", 32'(v), 32'd2);
        wait_zero();
        rd(4'd2, v); chk("R5 new C at wrap", 32'(v), 32'd5);
        sample_period(12, 5, 4, 7, 9, 1'b0);

        // R10 shadow flags stay quiet
        wr(4'd10, 16'h00FF);
        wait_zero();
        wait_zero();
        rd(4'd10, v);
        chk("R10 flags with buffering", 32'(v & 16'hFF), 32'h33);

        // R6 R7 channel 1 bits inert except C pin gate
        wr(4'd0, 16'h0019);
        wr(4'd8, 16'd3);
        wr(4'd9, 16'd1);
        wr(4'd4, 16'd1);
        wait_zero();
        wait_zero();
        rd(4'd6, v); chk("R6 ch1 A untouched", 32'(v), 32'd7);
        rd(4'd7, v); chk("R6 ch1 B untouched", 32'(v), 32'd9);
        rd(4'd2, v); chk("R6 ch0 A untouched", 32'(v), 32'd5);
        sample_period(12, 5, 4, 7, 9, 1'b1);

        // R9 all flags set when unbuffered
        wr(4'd10, 16'h00FF);
        wait_zero();
        wait_zero();
        rd(4'd10, v);
        chk("R9 all flags set", 32'(v & 16'hFF), 32'hFF);

        // R11 clear and set priority
        wr(4'd0, 16'h0000);
        wr(4'd10, 16'h0001);
        rd(4'd10, v);
        chk("R11 write-one clears", 32'(v & 16'hFF), 32'hFE);
        wr(4'd10, 16'h0000);
        rd(4'd10, v);
        chk("R11 write-zero keeps", 32'(v & 16'hFF), 32'hFE);
        wr(4'd0, 16'h0001);
        do begin @(negedge clk); rd(4'd11, v); end while (v != 16'd5);
        wr_en = 1'b1; wr_addr = 4'd10; wr_data = 16'h0001;
        @(negedge clk);
        wr_en = 1'b0;
        rd(4'd10, v);
        chk("R11 set wins over clear", 32'(v[0]), 32'd1);
        wr(4'd10, 16'h0001);
        rd(4'd10, v);
        chk("R11 clear off-match", 32'(v & 16'hFF), 32'hFE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule